// File: doc/BRIEF.md
# Split-Point Approximate Adder

This block adds two unsigned operands and deliberately gives up a little accuracy to keep the low end of the adder free of carry logic. Each operand is cut at a parameterised split point. The bits above the split are added exactly, with a carry-in of zero. The bits below the split are formed without any carry chain. Each low position is either the XOR of its two input bits or is forced to 1. A bit is forced to 1 when it lies at or below the most significant low position where both inputs are 1. Carries produced in the low section are dropped and never reach the upper section.

The approximate sum, the exact sum and a valid flag are captured in one output register stage. The exact sum lets a surrounding test environment measure the error, which is the exact sum minus the approximate one. By construction this error is never negative and is always smaller than two to the power of the low-section width. The block suits datapaths that can tolerate small errors in their least significant bits, such as audio or image filtering.

Top module: `apx_split_adder`

## Requirements
- R1: While `rst` is 1 at a rising edge of `clk`, `valid_q`, `sum_q` and `exact_q` are all cleared to 0 at that edge.
- R2: `valid_q` equals the value `in_valid` had at the previous rising edge.
- R3: After an edge with `in_valid` = 1, `sum_q[W:LOW]` equals `a[W-1:LOW] + b[W-1:LOW]` as an unsigned (W-LOW+1)-bit value. Nothing from bits below `LOW` contributes to it.
- R4: Let k be the highest position below `LOW` where `a` and `b` are both 1. For every low position above k, `sum_q` holds `a XOR b` for that position.
- R5: Every low bit of `sum_q` at position k and below (k as in R4) is 1.
- R6: When no low position has both `a` and `b` equal to 1, `sum_q[LOW-1:0]` equals `a[LOW-1:0] XOR b[LOW-1:0]`, which is also the exact low sum.
- R7: After an edge with `in_valid` = 1, `exact_q` equals the full (W+1)-bit sum `a + b`.
- R8: With the default split (W=16, LOW=8), `a` = 0x000F and `b` = 0x000F give `sum_q` = 0x000F while `exact_q` = 0x001E.
- R9: The error `exact_q - sum_q` is always at least 0 and below 2^LOW.
- R10: After an edge with `in_valid` = 0 (and `rst` = 0), `sum_q` and `exact_q` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on `a` and `b` are to be added |
| a | input | W | First unsigned operand |
| b | input | W | Second unsigned operand |
| sum_q | output | W+1 | Registered approximate sum |
| valid_q | output | 1 | Registered copy of `in_valid` |
| exact_q | output | W+1 | Registered exact sum, kept for error measurement |

## Verification
The bench sweeps every combination of the two 8-bit low sections, paired with varied upper bytes, so that every position of the first double-1 pair is reached. The sweep also includes upper sums that carry out of bit 15. A design that let a low carry leak upward would show up as upper-section mismatches. A design that forced the wrong bits, or scanned from the bottom instead of the top, would give wrong low bits or an error outside the 0 to 255 band. Directed cases cover the 0x000F + 0x000F pair, reset, and the valid flag. They also cover idle cycles, where a design that kept loading the registers would change its held results.

// File: rtl/apx_split_adder.sv
module apx_split_adder #(
  parameter int W   = 16,
  parameter int LOW = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W:0]   sum_q,
  output logic         valid_q,
  output logic [W:0]   exact_q
);
  localparam int HI = W - LOW;

  logic [LOW-1:0] both1, diff, force1, lo_sum;
  logic [HI:0]    hi_sum;

  assign both1 = a[LOW-1:0] & b[LOW-1:0];
  assign diff  = a[LOW-1:0] ^ b[LOW-1:0];

  // control signals: high from the topmost double-1 pair downward
  assign force1[LOW-1] = both1[LOW-1];
  for (genvar i = 0; i < LOW - 1; i++) begin : g_ctl
    assign force1[i] = force1[i+1] | both1[i];
  end

  assign lo_sum = diff | force1;
  assign hi_sum = {1'b0, a[W-1:LOW]} + {1'b0, b[W-1:LOW]};

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      sum_q   <= '0;
      exact_q <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        sum_q   <= {hi_sum, lo_sum};
        exact_q <= {1'b0, a} + {1'b0, b};
      end
    end
  end
endmodule

// File: rtl/apx_split_adder_chk.sv
module apx_split_adder_chk #(
  parameter int W   = 16,
  parameter int LOW = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [W:0]   sum_q,
  input logic         valid_q,
  input logic [W:0]   exact_q
);
  localparam int HI = W - LOW;
  localparam logic [W:0] ERR_LIM = (W+1)'(1) << LOW;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!valid_q && sum_q == '0 && exact_q == '0));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> valid_q);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !valid_q);

  // R3
  upper_exact_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> sum_q[W:LOW] == $past({1'b0, a[W-1:LOW]} + {1'b0, b[W-1:LOW]}));

  // R7
  exact_ref_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> exact_q == $past({1'b0, a} + {1'b0, b}));

  // R9
  error_band_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> (exact_q >= sum_q && (exact_q - sum_q) < ERR_LIM));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(sum_q) && $stable(exact_q)));

  logic [HI-1:0] unused_hi;
  assign unused_hi = '0;
endmodule

bind apx_split_adder apx_split_adder_chk #(.W(W), .LOW(LOW)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b),
  .sum_q(sum_q), .valid_q(valid_q), .exact_q(exact_q)
);

// File: tb/tb_apx_split_adder.sv
`timescale 1ns/1ps
module tb_apx_split_adder;
  localparam int W = 16;
  localparam int LOW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [W:0] sum_q, exact_q;
  logic valid_q;
  int checks = 0, errors = 0, max_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  apx_split_adder #(.W(W), .LOW(LOW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b),
    .sum_q(sum_q), .valid_q(valid_q), .exact_q(exact_q)
  );

  function automatic logic [W:0] model_apx(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [LOW-1:0] r;
    int k;
    k = -1;
    for (int i = LOW - 1; i >= 0; i--) if (k < 0 && x[i] && y[i]) k = i;
    r = x[LOW-1:0] ^ y[LOW-1:0];
    if (k >= 0) for (int i = 0; i <= k; i++) r[i] = 1'b1;
    return {({1'b0, x[W-1:LOW]} + {1'b0, y[W-1:LOW]}), r};
  endfunction

  task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    a = x; b = y; in_valid = 1'b1;
    @(negedge clk);
  endtask

  task automatic verify(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] e, ap;
    e  = {1'b0, x} + {1'b0, y};
    ap = model_apx(x, y);
    check("R3 upper", {{LOW{1'b0}}, sum_q[W:LOW]}, {{LOW{1'b0}}, ap[W:LOW]});
    if ((x[LOW-1:0] & y[LOW-1:0]) != '0)
      check("R4/R5 low", {{(W+1-LOW){1'b0}}, sum_q[LOW-1:0]}, {{(W+1-LOW){1'b0}}, ap[LOW-1:0]});
    else
      check("R6 low", {{(W+1-LOW){1'b0}}, sum_q[LOW-1:0]}, {{(W+1-LOW){1'b0}}, e[LOW-1:0]});
    check("R7 exact", exact_q, e);
    check("R9 band", {16'd0, (exact_q >= sum_q) && ((exact_q - sum_q) < (W+1)'(1 << LOW))}, 17'd1);
    if (int'(exact_q - sum_q) > max_err) max_err = int'(exact_q - sum_q);
  endtask

  initial begin
    logic [W:0] held_s, held_e;
    a = 16'h1234; b = 16'h4321; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 valid", {16'd0, valid_q}, 17'd0);
    check("R1 sum", sum_q, 17'd0);
    check("R1 exact", exact_q, 17'd0);
    rst = 1'b0;

    apply(16'h000F, 16'h000F);
    check("R8 apx", sum_q, 17'h000F);
    check("R8 exact", exact_q, 17'h001E);
    check("R2 valid high", {16'd0, valid_q}, 17'd1);

    apply(16'hFFFF, 16'hFFFF); verify(16'hFFFF, 16'hFFFF);
    apply(16'h8080, 16'h8000); verify(16'h8080, 16'h8000);
    apply(16'h0155, 16'h02AA); verify(16'h0155, 16'h02AA);

    held_s = sum_q; held_e = exact_q;
    @(negedge clk);
    a = 16'hABCD; b = 16'h5555; in_valid = 1'b0;
    @(negedge clk);
    check("R2 valid low", {16'd0, valid_q}, 17'd0);
    check("R10 sum hold", sum_q, held_s);
    check("R10 exact hold", exact_q, held_e);
    @(negedge clk);
    check("R10 sum hold 2", sum_q, held_s);

    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        logic [W-1:0] x, y;
        x = {8'(i * 37 + j), 8'(i)};
        y = {8'(j * 91 + i), 8'(j)};
        apply(x, y);
        verify(x, y);
      end
    end
    $display("max error magnitude %0d", max_err);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule